// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends a short command frame from a reader toward a tag over one carrier-enable line. Each bit starts with a fixed carrier-off gap. After the gap the carrier comes back on, and the total length of the bit period tells the receiver the value. A long period stands for a one and a short period stands for a zero. Before a bit is sent, its data value is whitened: it is XORed with one bit from an external keystream source. The block tells that source to move forward through a one-cycle strobe.

The datapath runs on the system clock. All timing is counted in ticks, and one tick is `TICK_DIV` system clocks. A frame starts when a start strobe arrives together with a nonzero bit count. The block sends that many bits from the data word, least significant bit first. It then adds one closing carrier-off gap and pulses done. A tick counter restarts when the frame is accepted and again at the closing edge of the frame. From the closing edge it counts the time that has passed, so the surrounding logic can time the reply window.

Top module: `pulse_pause_tx`

## Requirements
- R1: After reset, carrier_o is 1 and busy_o, done_o and ks_step_o are 0. Whenever busy_o is 0, carrier_o is 1.
- R2: A start_i pulse while idle with nbits_i in 1..15 begins a frame. In the next cycle carrier_o is 0 and busy_o is 1.
- R3: Every bit begins with carrier_o at 0 for exactly PAUSE_TICKS ticks (default 30).
- R4: The value sent for a bit is data bit XOR ks_bit_i, with ks_bit_i sampled on the edge where the gap ends. A sent 1 lasts ONE_TICKS ticks in total (default 150) and a sent 0 lasts ZERO_TICKS ticks (default 90). Both totals include the gap.
- R5: The bits sent are data_i[0] first, then upward. Exactly nbits_i bits are sent.
- R6: ks_step_o is a one-cycle pulse on the edge where carrier_o returns to 1 inside a bit. A frame produces exactly nbits_i pulses.
- R7: After the last bit, carrier_o is 0 for PAUSE_TICKS ticks. It then returns to 1, and on the same edge done_o pulses for one cycle and busy_o falls.
- R8: A start_i pulse has no effect while busy_o is 1, and that includes the cycle that closes the frame. A start_i pulse with nbits_i = 0 also has no effect.
- R9: frame_time_o is 0 in the done cycle. From the closing edge on it reads k exactly k*TICK_DIV clocks later, and it saturates at its maximum.
- R10: One tick is TICK_DIV system clocks, counted from the edge that accepted the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start strobe |
| data_i | input | DATA_W | Frame payload, sent LSB first |
| nbits_i | input | CNT_W | Number of bits to send (1..DATA_W) |
| ks_bit_i | input | 1 | Current keystream bit |
| carrier_o | output | 1 | Carrier enable, 1 = on |
| ks_step_o | output | 1 | Keystream advance strobe |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| frame_time_o | output | TIME_W | Ticks since the last frame start or end |

## Verification
The interesting coincidence is a new start request arriving at the end of a frame. The closing edge, which raises carrier, pulses done and clears the tick counter, can fall in the same cycle as a new start. The bench holds start_i high from the last gap cycle through the closing edge. It expects the request at the closing edge to be dropped, so busy_o must be low in the done cycle. The same still-high strobe is then taken on the following edge, which gives a back-to-back frame. That second frame is checked bit by bit against a keystream model, to confirm nothing from the dropped request leaked into it.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_GAP   = 2'd1,
        PH_HOLD  = 2'd2,
        PH_CLOSE = 2'd3
    } phase_e;

    typedef struct packed {
        logic carrier;
        logic step;
        logic done;
    } line_t;

    function automatic int unsigned span_ticks(logic v, int unsigned long_t,
                                               int unsigned short_t);
        return v ? long_t : short_t;
    endfunction

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ppt_prescaler.sv
module ppt_prescaler #(
    parameter int unsigned DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_clr,
    output logic tick
);
    import ppt_pkg::*;

    localparam int unsigned W = width_of(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || sync_clr) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_gap
            // R10
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ppt_frame_timer.sv
module ppt_frame_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R9
    timer_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt_q == TOP) |=> cnt_q == TOP);

endmodule

// File: rtl/ppt_sequencer.sv
module ppt_sequencer #(
    parameter int unsigned DATA_W  = 15,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned GAP_T   = 30,
    parameter int unsigned LONG_T  = 150,
    parameter int unsigned SHORT_T = 90
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              ks_bit,
    output logic              carrier,
    output logic              ks_step,
    output logic              done,
    output logic              busy,
    output logic              restart
);
    import ppt_pkg::*;

    localparam int unsigned SEG_W = width_of(LONG_T + 1);
    localparam logic [SEG_W-1:0] GAP_LAST   = SEG_W'(GAP_T - 1);
    localparam logic [SEG_W-1:0] LONG_LAST  = SEG_W'(LONG_T - 1);
    localparam logic [SEG_W-1:0] SHORT_LAST = SEG_W'(SHORT_T - 1);

    phase_e            phase_q;
    line_t             line_q;
    logic [SEG_W-1:0]  seg_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;
    logic              cur_q;

    logic accept;
    logic gap_end;
    logic bit_end;
    logic frame_end;
    logic [SEG_W-1:0] bit_last;

    assign accept    = (phase_q == PH_IDLE) && start && (nbits != '0);
    assign gap_end   = tick && (seg_q == GAP_LAST);
    assign bit_last  = (span_ticks(cur_q, LONG_T, SHORT_T) == LONG_T) ? LONG_LAST
                                                                      : SHORT_LAST;
    assign bit_end   = (phase_q == PH_HOLD) && tick && (seg_q == bit_last);
    assign frame_end = (phase_q == PH_CLOSE) && gap_end;
    assign restart   = accept || frame_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            line_q  <= '{carrier: 1'b1, step: 1'b0, done: 1'b0};
            seg_q   <= '0;
            shreg_q <= '0;
            left_q  <= '0;
            cur_q   <= 1'b0;
        end else begin
            line_q.step <= 1'b0;
            line_q.done <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q        <= PH_GAP;
                        line_q.carrier <= 1'b0;
                        seg_q          <= '0;
                        shreg_q        <= data;
                        left_q         <= nbits;
                    end
                end
                PH_GAP: begin
                    if (gap_end) begin
                        phase_q        <= PH_HOLD;
                        line_q.carrier <= 1'b1;
                        line_q.step    <= 1'b1;
                        cur_q          <= shreg_q[0] ^ ks_bit;
                        seg_q          <= seg_q + 1'b1;
                    end else if (tick) begin
                        seg_q <= seg_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (bit_end) begin
                        line_q.carrier <= 1'b0;
                        seg_q          <= '0;
                        shreg_q        <= shreg_q >> 1;
                        left_q         <= left_q - 1'b1;
                        phase_q        <= (left_q == CNT_W'(1)) ? PH_CLOSE : PH_GAP;
                    end else if (tick) begin
                        seg_q <= seg_q + 1'b1;
                    end
                end
                PH_CLOSE: begin
                    if (frame_end) begin
                        phase_q        <= PH_IDLE;
                        line_q.carrier <= 1'b1;
                        line_q.done    <= 1'b1;
                        seg_q          <= '0;
                    end else if (tick) begin
                        seg_q <= seg_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign carrier = line_q.carrier;
    assign ks_step = line_q.step;
    assign done    = line_q.done;
    assign busy    = (phase_q != PH_IDLE);

    // R1
    idle_carrier_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> carrier);

    // R3
    carrier_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(carrier) |-> busy);

    // R6
    step_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ks_step |-> (carrier && phase_q == PH_HOLD));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (carrier && !busy));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !frame_end) |=> busy);

endmodule

// File: rtl/pulse_pause_tx.sv
module pulse_pause_tx #(
    parameter int unsigned TICK_DIV    = 32,
    parameter int unsigned DATA_W      = 15,
    parameter int unsigned PAUSE_TICKS = 30,
    parameter int unsigned ONE_TICKS   = 150,
    parameter int unsigned ZERO_TICKS  = 90,
    parameter int unsigned TIME_W      = 16,
    parameter int unsigned CNT_W       = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic              ks_bit_i,
    output logic              carrier_o,
    output logic              ks_step_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [TIME_W-1:0] frame_time_o
);
    logic tick;
    logic restart;

    ppt_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .sync_clr (restart),
        .tick     (tick)
    );

    ppt_frame_timer #(.W(TIME_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (restart),
        .tick  (tick),
        .count (frame_time_o)
    );

    ppt_sequencer #(
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .GAP_T   (PAUSE_TICKS),
        .LONG_T  (ONE_TICKS),
        .SHORT_T (ZERO_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (start_i),
        .data    (data_i),
        .nbits   (nbits_i),
        .ks_bit  (ks_bit_i),
        .carrier (carrier_o),
        .ks_step (ks_step_o),
        .done    (done_o),
        .busy    (busy_o),
        .restart (restart)
    );

    // R9
    done_time_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (frame_time_o == '0));

endmodule

// File: tb/pulse_pause_tx_tb_top.sv
module pulse_pause_tx_tb_top;

    localparam int D     = 2;
    localparam int DW    = 15;
    localparam int CW    = 4;
    localparam int GAP   = 30;
    localparam int LONG  = 150;
    localparam int SHORT = 90;
    localparam int TW    = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [DW-1:0] data_i;
    logic [CW-1:0] nbits_i;
    logic          ks_bit_i;
    logic          carrier_o, ks_step_o, busy_o, done_o;
    logic [TW-1:0] frame_time_o;
    logic [6:0]    lfsr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pulse_pause_tx #(
        .TICK_DIV(D), .DATA_W(DW), .PAUSE_TICKS(GAP),
        .ONE_TICKS(LONG), .ZERO_TICKS(SHORT), .TIME_W(TW), .CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
        .nbits_i(nbits_i), .ks_bit_i(ks_bit_i), .carrier_o(carrier_o),
        .ks_step_o(ks_step_o), .busy_o(busy_o), .done_o(done_o),
        .frame_time_o(frame_time_o)
    );

    function automatic logic [6:0] lfsr_next(logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    always @(posedge clk) begin
        if (rst) lfsr <= 7'h55;
        else if (ks_step_o) lfsr <= lfsr_next(lfsr);
    end
    assign ks_bit_i = lfsr[0];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge. Sends one frame and returns at the negedge of the done cycle.
    // mid_start: inject a start pulse during the first bit. hold_end: raise start before the closing edge.
    task automatic run_frame(input logic [DW-1:0] d, input int n,
                             input logic mid_start, input logic hold_end);
        logic [6:0] k;
        logic [DW-1:0] sent;
        int cnt;
        int steps;
        k = lfsr;
        for (int i = 0; i < n; i++) begin
            sent[i] = d[i] ^ k[0];
            k = lfsr_next(k);
        end
        start_i = 1'b1; data_i = d; nbits_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0;
        chk(carrier_o == 1'b0 && busy_o == 1'b1, "R2 frame begins", {30'd0, carrier_o, busy_o}, 1);
        chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        steps = 0;
        for (int i = 0; i < n; i++) begin
            cnt = 0;
            while (carrier_o == 1'b0 && cnt < 100000) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == GAP * D, "R3 bit gap length (R10 tick)", cnt, GAP * D);
            chk(ks_step_o == 1'b1, "R6 step at gap end", ks_step_o, 1);
            cnt = 0;
            while (carrier_o == 1'b1 && cnt < 100000) begin
                if (ks_step_o) steps++;
                if (mid_start && i == 0 && cnt == 2) begin
                    start_i = 1'b1; data_i = ~d; nbits_i = 4'd1;
                end else begin
                    start_i = 1'b0;
                end
                cnt++;
                @(negedge clk);
            end
            start_i = 1'b0;
            chk(cnt == ((sent[i] ? LONG : SHORT) - GAP) * D,
                $sformatf("R4 R5 bit %0d duration", i), cnt,
                ((sent[i] ? LONG : SHORT) - GAP) * D);
        end
        chk(steps == n, "R6 step count", steps, n);
        cnt = 0;
        while (carrier_o == 1'b0 && cnt < 100000) begin
            cnt++;
            if (hold_end && cnt == GAP * D) begin
                start_i = 1'b1; data_i = 15'h7fff; nbits_i = 4'd3;
            end
            @(negedge clk);
        end
        chk(cnt == GAP * D, "R7 closing gap", cnt, GAP * D);
        chk(done_o == 1'b1 && carrier_o == 1'b1, "R7 done with carrier on",
            {30'd0, done_o, carrier_o}, 3);
        chk(busy_o == 1'b0, "R8 no restart on closing edge", busy_o, 0);
        chk(frame_time_o == '0, "R9 timer zero at done", frame_time_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all actual=timeout(0) expected=finish(1)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        rst = 1'b1; start_i = 1'b0; data_i = '0; nbits_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(carrier_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0 && ks_step_o == 1'b0,
            "R1 reset state", {28'd0, carrier_o, busy_o, done_o, ks_step_o}, 8);

        // R8 nbits = 0 ignored
        start_i = 1'b1; data_i = 15'h1234; nbits_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0 && carrier_o == 1'b1, "R8 zero count ignored",
            {30'd0, busy_o, carrier_o}, 1);

        // directed corners: single bit, full width, patterns
        run_frame(15'h0001, 1, 1'b0, 1'b0);
        @(negedge clk);
        run_frame(15'h7fff, 15, 1'b0, 1'b0);
        @(negedge clk);
        run_frame(15'h0000, 15, 1'b0, 1'b0);

        // R9 timer from frame end, R10 tick length
        repeat (7 * D) @(negedge clk);
        chk(frame_time_o == 16'd7, "R9 R10 timer after done", frame_time_o, 7);

        // R8 start while busy ignored
        run_frame(15'h2a5c, 9, 1'b1, 1'b0);

        // coincidence: start at closing edge dropped, then back-to-back frame
        @(negedge clk);
        run_frame(15'h0f0f, 6, 1'b0, 1'b1);
        run_frame(15'h1357, 8, 1'b0, 1'b0);

        // constrained random frames
        for (int r = 0; r < 6; r++) begin
            logic [DW-1:0] rd;
            int rn;
            rd = DW'($urandom);
            rn = 1 + int'($urandom % 15);
            repeat (1 + int'($urandom % 5)) @(negedge clk);
            run_frame(rd, rn, r[0], 1'b0);
        end

        @(negedge clk);
        chk(carrier_o == 1'b1 && busy_o == 1'b0, "R1 idle after frames",
            {30'd0, carrier_o, busy_o}, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule